// File: doc/BRIEF.md
# Audio clock ratio autodetector

This block watches the three clocks of a serial audio port (master clock, bit clock and frame clock) and works out how they relate. All three are sampled as plain data in the domain of a free-running internal oscillator. For every frame it counts oscillator cycles, bit-clock rising edges and master-clock rising edges. The frame length in oscillator cycles places the stream in one of four sample-rate groups. The bit-clock count per frame gives the bit-clock ratio, which must be one of three legal values.

A new result is published only when two frames in a row agree. Software can pin the rate group to a written code. The pin is forced whenever de-emphasis or AM interference avoidance is on, even while automatic mode is requested. A select output chooses the oscillator as core clock whenever the master clock has gone quiet or has not yet held a steady edge count over several frames.

Top module: `audio_clk_detect`

## Requirements
- R1: The bit-clock ratio output is 0 for 32 rising bit-clock edges per frame, 1 for 48 and 2 for 64. Any other count gives 3, meaning illegal.
- R2: With P the frame period in oscillator cycles, the detected group is 3 (quad) when P < TH_QUAD, 2 (double) when P < TH_DOUBLE, 1 (normal) when P < TH_NORMAL, and 0 (32 kHz) otherwise.
- R3: The detected group and ratio change only when two consecutive frame measurements give the same group and ratio. A single differing frame leaves both outputs unchanged.
- R4: clk_valid is 1 only once a confirmed result exists and its ratio is legal (not 3).
- R5: When auto_en is 0, or deemph_en is 1, or am_avoid_en is 1, rate_grp equals manual_rate from the next cycle on. bclk_ratio is not affected. When all three conditions clear, rate_grp returns to the detected group.
- R6: If no master-clock rising edge is seen for MCLK_TIMEOUT oscillator cycles, use_osc goes to 1.
- R7: use_osc is 0 only after STABLE_FRAMES consecutive frames carry an identical, non-zero master-clock edge count. A differing count sets it back to 1.
- R8: After reset, rate_grp is 0, bclk_ratio is 3, clk_valid is 0 and use_osc is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| mclk_in | input | 1 | Master clock, sampled as data |
| bclk_in | input | 1 | Bit clock, sampled as data |
| lrclk_in | input | 1 | Frame clock, one rising edge per sample period |
| auto_en | input | 1 | 1 selects the detected rate group |
| deemph_en | input | 1 | De-emphasis active; forces the manual rate code |
| am_avoid_en | input | 1 | AM interference avoidance active; forces the manual rate code |
| manual_rate | input | 2 | Rate code written by software (0 = 32 kHz, 1 = normal, 2 = double, 3 = quad) |
| rate_grp | output | 2 | Rate group in use, same encoding as manual_rate |
| bclk_ratio | output | 2 | Confirmed bit-clock ratio (0 = 32, 1 = 48, 2 = 64, 3 = illegal) |
| clk_valid | output | 1 | Confirmed and legal clocking |
| use_osc | output | 1 | 1 picks the oscillator as core clock, 0 picks the master clock |

## Verification
The manual override and a confirmed detection update can land on the same cycle. In that case rate_grp must show the written code while the detected group moves underneath it. The bench provokes this by changing the stream's rate group and, in the same stretch of frames, setting random combinations of auto_en, deemph_en and am_avoid_en. It judges rate_grp against a bench function that chooses between the manual code and the group predicted from the frame period. It also checks that bclk_ratio still follows the stream unaffected.

// File: rtl/acd_pkg.sv
package acd_pkg;

    localparam int BITS_W = 8;

    typedef enum logic [1:0] {
        GRP_32K    = 2'd0,
        GRP_NORMAL = 2'd1,
        GRP_DOUBLE = 2'd2,
        GRP_QUAD   = 2'd3
    } rate_grp_e;

    typedef enum logic [1:0] {
        BR_32  = 2'd0,
        BR_48  = 2'd1,
        BR_64  = 2'd2,
        BR_BAD = 2'd3
    } bclk_ratio_e;

    typedef struct packed {
        rate_grp_e   grp;
        bclk_ratio_e ratio;
    } det_res_t;

    localparam det_res_t DET_RESET = '{grp: GRP_32K, ratio: BR_BAD};

    function automatic bclk_ratio_e ratio_of(input logic [BITS_W-1:0] bits);
        case (bits)
            8'd32:   return BR_32;
            8'd48:   return BR_48;
            8'd64:   return BR_64;
            default: return BR_BAD;
        endcase
    endfunction

    function automatic rate_grp_e grp_of(input logic [31:0] per,
                                         input logic [31:0] th_q,
                                         input logic [31:0] th_d,
                                         input logic [31:0] th_n);
        if (per < th_q)      return GRP_QUAD;
        else if (per < th_d) return GRP_DOUBLE;
        else if (per < th_n) return GRP_NORMAL;
        else                 return GRP_32K;
    endfunction

endpackage

// File: rtl/acd_edge_sync.sv
module acd_edge_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    logic [N-1:0] s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
endmodule

// File: rtl/acd_frame_meter.sv
module acd_frame_meter
    import acd_pkg::*;
#(
    parameter int PER_W        = 12,
    parameter int MCLK_TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lr_rise,
    input  logic              b_rise,
    input  logic              m_rise,
    output logic              meas_vld,
    output logic [PER_W-1:0]  meas_per,
    output logic [BITS_W-1:0] meas_bits,
    output logic [PER_W-1:0]  meas_mcnt,
    output logic              m_absent
);
    localparam int IDLE_W = $clog2(MCLK_TIMEOUT + 1);
    localparam logic [PER_W-1:0]  PER_MAX  = '1;
    localparam logic [BITS_W-1:0] BITS_MAX = '1;
    localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(MCLK_TIMEOUT);

    logic [PER_W-1:0]  per_cnt;
    logic [BITS_W-1:0] bit_cnt;
    logic [PER_W-1:0]  m_cnt;
    logic [IDLE_W-1:0] idle_cnt;
    logic [BITS_W-1:0] bits_next;
    logic [PER_W-1:0]  mcnt_next;

    always_comb begin
        bits_next = (b_rise && bit_cnt != BITS_MAX) ? bit_cnt + 1'b1 : bit_cnt;
        mcnt_next = (m_rise && m_cnt != PER_MAX) ? m_cnt + 1'b1 : m_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_cnt   <= '0;
            bit_cnt   <= '0;
            m_cnt     <= '0;
            idle_cnt  <= '0;
            meas_vld  <= 1'b0;
            meas_per  <= '0;
            meas_bits <= '0;
            meas_mcnt <= '0;
        end else begin
            meas_vld <= lr_rise;
            if (lr_rise) begin
                meas_per  <= per_cnt;
                meas_bits <= bits_next;
                meas_mcnt <= mcnt_next;
                per_cnt   <= PER_W'(1);
                bit_cnt   <= '0;
                m_cnt     <= '0;
            end else begin
                if (per_cnt != PER_MAX) per_cnt <= per_cnt + 1'b1;
                bit_cnt <= bits_next;
                m_cnt   <= mcnt_next;
            end
            if (m_rise)                    idle_cnt <= '0;
            else if (idle_cnt != IDLE_LIM) idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign m_absent = (idle_cnt == IDLE_LIM);

    // R2: a measurement is only published right after a frame edge
    a_r2_meas_after_frame: assert property (@(posedge clk) disable iff (rst)
        meas_vld |-> $past(lr_rise));

    // R6: a master-clock edge always lifts the absence flag
    a_r6_edge_clears_absent: assert property (@(posedge clk) disable iff (rst)
        m_rise |=> !m_absent);
endmodule

// File: rtl/acd_confirm.sv
module acd_confirm
    import acd_pkg::*;
#(
    parameter int PER_W         = 12,
    parameter int TH_QUAD       = 390,
    parameter int TH_DOUBLE     = 780,
    parameter int TH_NORMAL     = 1350,
    parameter int STABLE_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              meas_vld,
    input  logic [PER_W-1:0]  meas_per,
    input  logic [BITS_W-1:0] meas_bits,
    input  logic [PER_W-1:0]  meas_mcnt,
    input  logic              m_absent,
    output det_res_t          det,
    output logic              det_ok,
    output logic              mclk_stable
);
    localparam int STAB_W = $clog2(STABLE_FRAMES + 1);
    localparam logic [STAB_W-1:0] STAB_LIM = STAB_W'(STABLE_FRAMES - 1);

    det_res_t          cand, prev;
    logic              have_prev;
    logic [PER_W-1:0]  prev_mcnt;
    logic [STAB_W-1:0] stab_cnt;

    always_comb begin
        cand.grp   = grp_of(32'(meas_per), 32'(TH_QUAD), 32'(TH_DOUBLE), 32'(TH_NORMAL));
        cand.ratio = ratio_of(meas_bits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det       <= DET_RESET;
            det_ok    <= 1'b0;
            prev      <= DET_RESET;
            have_prev <= 1'b0;
            prev_mcnt <= '0;
            stab_cnt  <= '0;
        end else begin
            if (meas_vld) begin
                prev      <= cand;
                have_prev <= 1'b1;
                if (have_prev && cand == prev) begin
                    det    <= cand;
                    det_ok <= 1'b1;
                end
            end
            if (m_absent) begin
                stab_cnt <= '0;
            end else if (meas_vld) begin
                prev_mcnt <= meas_mcnt;
                if (meas_mcnt == prev_mcnt && meas_mcnt != '0) begin
                    if (stab_cnt != STAB_LIM) stab_cnt <= stab_cnt + 1'b1;
                end else begin
                    stab_cnt <= '0;
                end
            end
        end
    end

    assign mclk_stable = (stab_cnt == STAB_LIM);

    // R3: the confirmed result moves only on a measurement that follows another
    a_r3_update_on_pair: assert property (@(posedge clk) disable iff (rst)
        !$stable(det) |-> ($past(meas_vld) && $past(have_prev)));

    // R7: a missing master clock withdraws stability at once
    a_r7_absent_drops_stable: assert property (@(posedge clk) disable iff (rst)
        m_absent |=> !mclk_stable);
endmodule

// File: rtl/audio_clk_detect.sv
module audio_clk_detect
    import acd_pkg::*;
#(
    parameter int TH_QUAD       = 390,
    parameter int TH_DOUBLE     = 780,
    parameter int TH_NORMAL     = 1350,
    parameter int MCLK_TIMEOUT  = 256,
    parameter int STABLE_FRAMES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mclk_in,
    input  logic       bclk_in,
    input  logic       lrclk_in,
    input  logic       auto_en,
    input  logic       deemph_en,
    input  logic       am_avoid_en,
    input  logic [1:0] manual_rate,
    output logic [1:0] rate_grp,
    output logic [1:0] bclk_ratio,
    output logic       clk_valid,
    output logic       use_osc
);
    localparam int PER_W = $clog2(TH_NORMAL) + 2;

    logic [2:0]        rise;
    logic              meas_vld;
    logic [PER_W-1:0]  meas_per;
    logic [BITS_W-1:0] meas_bits;
    logic [PER_W-1:0]  meas_mcnt;
    logic              m_absent;
    det_res_t          det;
    logic              det_ok;
    logic              mclk_stable;
    logic              manual_sel;

    acd_edge_sync #(.N(3)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({mclk_in, bclk_in, lrclk_in}),
        .rise (rise)
    );

    acd_frame_meter #(.PER_W(PER_W), .MCLK_TIMEOUT(MCLK_TIMEOUT)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .lr_rise   (rise[0]),
        .b_rise    (rise[1]),
        .m_rise    (rise[2]),
        .meas_vld  (meas_vld),
        .meas_per  (meas_per),
        .meas_bits (meas_bits),
        .meas_mcnt (meas_mcnt),
        .m_absent  (m_absent)
    );

    acd_confirm #(
        .PER_W(PER_W), .TH_QUAD(TH_QUAD), .TH_DOUBLE(TH_DOUBLE),
        .TH_NORMAL(TH_NORMAL), .STABLE_FRAMES(STABLE_FRAMES)
    ) u_confirm (
        .clk         (clk),
        .rst         (rst),
        .meas_vld    (meas_vld),
        .meas_per    (meas_per),
        .meas_bits   (meas_bits),
        .meas_mcnt   (meas_mcnt),
        .m_absent    (m_absent),
        .det         (det),
        .det_ok      (det_ok),
        .mclk_stable (mclk_stable)
    );

    assign manual_sel = !auto_en || deemph_en || am_avoid_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_grp   <= GRP_32K;
            bclk_ratio <= BR_BAD;
            clk_valid  <= 1'b0;
            use_osc    <= 1'b1;
        end else begin
            rate_grp   <= manual_sel ? manual_rate : det.grp;
            bclk_ratio <= det.ratio;
            clk_valid  <= det_ok && (det.ratio != BR_BAD);
            use_osc    <= m_absent || !mclk_stable;
        end
    end

    // R5: a forced manual selection shows the written code one cycle later
    a_r5_manual_code: assert property (@(posedge clk) disable iff (rst)
        manual_sel |=> rate_grp == $past(manual_rate));

    // R4: valid clocking never coexists with an illegal ratio
    a_r4_valid_legal: assert property (@(posedge clk) disable iff (rst)
        clk_valid |-> bclk_ratio != 2'd3);

    // R6: an absent master clock selects the oscillator
    a_r6_absent_osc: assert property (@(posedge clk) disable iff (rst)
        m_absent |=> use_osc);
endmodule

// File: tb/tb_audio_clk_detect.sv
module tb_audio_clk_detect;
    localparam int TQ  = 192;
    localparam int TD  = 384;
    localparam int TN  = 640;
    localparam int MTO = 64;
    localparam int NST = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mclk = 1'b0, bclk = 1'b0, lrclk = 1'b0;
    logic       auto_en = 1'b1, deemph_en = 1'b0, am_avoid_en = 1'b0;
    logic [1:0] manual_rate = 2'd0;
    logic [1:0] rate_grp, bclk_ratio;
    logic       clk_valid, use_osc;

    int errors = 0;
    int checks = 0;
    int m_half = 1;
    int mcnt   = 0;
    int fcount = 0;
    bit jitter = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    audio_clk_detect #(
        .TH_QUAD(TQ), .TH_DOUBLE(TD), .TH_NORMAL(TN),
        .MCLK_TIMEOUT(MTO), .STABLE_FRAMES(NST)
    ) dut (
        .clk(clk), .rst(rst), .mclk_in(mclk), .bclk_in(bclk), .lrclk_in(lrclk),
        .auto_en(auto_en), .deemph_en(deemph_en), .am_avoid_en(am_avoid_en),
        .manual_rate(manual_rate), .rate_grp(rate_grp), .bclk_ratio(bclk_ratio),
        .clk_valid(clk_valid), .use_osc(use_osc)
    );

    always @(negedge clk) begin
        if (m_half == 0) begin
            mclk <= 1'b0;
            mcnt <= 0;
        end else if (mcnt >= m_half - 1) begin
            mclk <= ~mclk;
            mcnt <= 0;
        end else begin
            mcnt <= mcnt + 1;
        end
    end

    function automatic int exp_grp(input int per);
        if (per < TQ)      return 3;
        else if (per < TD) return 2;
        else if (per < TN) return 1;
        else               return 0;
    endfunction

    function automatic int exp_ratio(input int bits);
        case (bits)
            32:      return 0;
            48:      return 1;
            64:      return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int exp_rate(input int bits, input int h);
        if (!auto_en || deemph_en || am_avoid_en) return int'(manual_rate);
        return exp_grp(bits * 2 * h);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_frame(input int bits, input int h);
        if (jitter) m_half = 1 + (fcount % 2);
        fcount++;
        for (int i = 0; i < bits; i++) begin
            for (int c = 0; c < 2 * h; c++) begin
                @(negedge clk);
                lrclk = (i < bits / 2);
                bclk  = (c >= h);
            end
        end
    endtask

    task automatic run_frames(input int bits, input int h, input int n);
        for (int k = 0; k < n; k++) run_frame(bits, h);
    endtask

    task automatic check_stream(input int bits, input int h);
        check("R2 rate group", int'(rate_grp), exp_rate(bits, h));
        check("R1 bit-clock ratio", int'(bclk_ratio), exp_ratio(bits));
        check("R4 clock valid", int'(clk_valid), (exp_ratio(bits) != 3) ? 1 : 0);
        check("R7 steady master clock selects mclk", int'(use_osc), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int bl [8] = '{32, 48, 32, 48, 64, 64, 40, 32};
        int hl [8] = '{2, 2, 3, 4, 5, 6, 3, 5};
        int pick [5] = '{32, 48, 64, 40, 56};
        void'($urandom(32'd7321));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset rate group", int'(rate_grp), 0);
        check("R8 reset ratio", int'(bclk_ratio), 3);
        check("R8 reset valid", int'(clk_valid), 0);
        check("R8 reset core clock select", int'(use_osc), 1);

        // R1 R2 R4: directed streams including exact threshold periods
        for (int t = 0; t < 8; t++) begin
            run_frames(bl[t], hl[t], 6);
            check_stream(bl[t], hl[t]);
        end

        // R3: two frames of a new stream are needed before results move
        run_frames(32, 2, 6);
        run_frames(64, 6, 2);
        check("R3 group held after one new measurement", int'(rate_grp), 3);
        check("R3 ratio held after one new measurement", int'(bclk_ratio), 0);
        run_frame(64, 6);
        check("R3 group after two matching measurements", int'(rate_grp), 0);
        check("R3 ratio after two matching measurements", int'(bclk_ratio), 2);

        // R3: a lone odd frame is ignored
        run_frames(48, 4, 6);
        run_frame(32, 2);
        run_frame(48, 4);
        check("R3 lone frame group ignored", int'(rate_grp), 1);
        check("R3 lone frame ratio ignored", int'(bclk_ratio), 1);

        // R5: each override source forces the manual code
        run_frames(48, 4, 6);
        manual_rate = 2'd3;
        deemph_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 de-emphasis forces manual code", int'(rate_grp), 3);
        check("R5 ratio unaffected", int'(bclk_ratio), 1);
        deemph_en = 1'b0; am_avoid_en = 1'b1; manual_rate = 2'd2;
        repeat (3) @(negedge clk);
        check("R5 AM avoidance forces manual code", int'(rate_grp), 2);
        am_avoid_en = 1'b0; auto_en = 1'b0; manual_rate = 2'd0;
        repeat (3) @(negedge clk);
        check("R5 manual mode uses code", int'(rate_grp), 0);
        auto_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 release returns detected group", int'(rate_grp), 1);

        // R6: master clock stops
        run_frames(32, 4, 6);
        m_half = 0;
        run_frame(32, 4);
        check("R6 absent master clock selects oscillator", int'(use_osc), 1);
        check("R6 detection continues", int'(bclk_ratio), 0);
        m_half = 1;
        run_frames(32, 4, 6);
        check("R7 recovered master clock", int'(use_osc), 0);

        // R7: frame-to-frame varying master clock count
        jitter = 1'b1;
        run_frames(48, 3, 6);
        check("R7 varying master clock keeps oscillator", int'(use_osc), 1);
        jitter = 1'b0;
        m_half = 1;
        run_frames(48, 3, 6);
        check("R7 steady again selects master clock", int'(use_osc), 0);

        // random streams with random override settings
        for (int it = 0; it < 12; it++) begin
            int b;
            int h;
            b = pick[$urandom % 5];
            h = 2 + int'($urandom % 5);
            auto_en     = ($urandom % 4) != 0;
            deemph_en   = ($urandom % 5) == 0;
            am_avoid_en = ($urandom % 5) == 0;
            manual_rate = 2'($urandom % 4);
            run_frames(b, h, 6);
            check_stream(b, h);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule